// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures how long a fan tachometer signal takes between two qualifying edges, counted in ticks of a prescaled system clock. The tach signal, or in loopback mode the local PWM drive, passes through a two-flop synchroniser. It then goes through a glitch filter of selectable length. An edge detector picks out the edges that bound each interval. The interval may be falling-to-falling, rising-to-rising, or the gap between any two consecutive edges.

Each interval's tick count is captured into a result field. An update flag and a complete-measurement flag go with it. Software turns the count into a speed; the true interval is the captured count plus one. A stalled fan lets the counter run up to its all-ones value. That value is captured at once and stays there.

An optional threshold comparison raises a sticky interrupt. The sense of the comparison can be inverted, so the interrupt can flag either a slow fan or a fast one. The bus decode sits outside the block and drives the configuration inputs directly. It also supplies one-cycle pulses for a status read and for a write-one-to-clear of the interrupt.

Top module: `fan_tach_period`

## Requirements
- R1: While `meas_en` is low, no capture happens and `meas_full` is 0. The first qualifying edge after `meas_en` rises only arms the counter and captures nothing.
- R2: `edge_sel` chooses the interval: 2'b00 falling-to-falling, 2'b01 rising-to-rising, 2'b10 or 2'b11 any edge to the next edge.
- R3: `deb_code` sets how many consecutive clocks a changed synchronised level must persist before the filtered level follows: 2'b00 three, 2'b01 two, 2'b10 one, 2'b11 no filter.
- R4: One tick is 4^`div_code` system clocks. The prescaler restarts at every qualifying edge.
- R5: The counter restarts at every qualifying edge. For an interval of D clocks, with D a multiple of the tick length T, the captured count is D/T - 1.
- R6: The count saturates at all ones (2^CNT_W - 1). Reaching it is captured immediately as a measurement.
- R7: `meas_full` is set by the first capture after enabling.
- R8: `meas_new` is set by each capture and cleared by a `stat_rd` pulse. A capture in the same cycle wins.
- R9: With `thr_irq_en` high and `thr_inv` low, a capture whose value is greater than `thr` sets `irq`. `irq` holds until an `irq_clr` pulse; a setting capture in the same cycle wins. With `thr_irq_en` low, `irq` never sets.
- R10: With `thr_inv` high, the interrupt condition becomes a captured value less than `thr`.
- R11: With `loop_en` high, `pwm_loop` replaces `tach_in` as the measured signal.
- R12: `raw_lvl` is the synchronised input, two clocks after a change. `deb_lvl` is the filtered level that the edge detector uses.
- R13: After reset, `meas_val`, `meas_full`, `meas_new` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 1 | Fan tachometer pulse input |
| pwm_loop | input | 1 | Local PWM output, measured in loopback |
| meas_en | input | 1 | Measurement enable |
| loop_en | input | 1 | Selects `pwm_loop` as the measured signal |
| edge_sel | input | 2 | Interval edge pair select |
| deb_code | input | 2 | Glitch filter length code |
| div_code | input | 4 | Prescaler code, tick = 4^code clocks |
| thr | input | CNT_W | Threshold for the interrupt compare |
| thr_irq_en | input | 1 | Threshold interrupt enable |
| thr_inv | input | 1 | Inverts the threshold compare sense |
| stat_rd | input | 1 | Status read pulse, clears `meas_new` |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| meas_val | output | CNT_W | Last captured count |
| meas_full | output | 1 | A complete measurement is held |
| meas_new | output | 1 | New value since the last status read |
| raw_lvl | output | 1 | Synchronised input level |
| deb_lvl | output | 1 | Filtered input level |
| irq | output | 1 | Sticky threshold interrupt |

## Verification
The bench puts a two-clock glitch inside a low phase under three-clock and then two-clock filtering. A filter that is one clock too short would capture a spurious half interval. In any-edge mode it drives unequal high and low phases, so a design that measured the wrong edge pair would report the other phase. A stalled input has to produce an all-ones capture without any further edge; a counter that wraps, or that waits for an edge, would show a small value or no update at all. The interrupt is checked in both senses and with the enable off. Filter latency is checked clock by clock, which catches an off-by-one in the length decode.

// File: rtl/fan_tach_period.sv
module fan_tach_period #(
  parameter int CNT_W = 20,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic             pwm_loop,
  input  logic             meas_en,
  input  logic             loop_en,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       deb_code,
  input  logic [DIV_W-1:0] div_code,
  input  logic [CNT_W-1:0] thr,
  input  logic             thr_irq_en,
  input  logic             thr_inv,
  input  logic             stat_rd,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] meas_val,
  output logic             meas_full,
  output logic             meas_new,
  output logic             raw_lvl,
  output logic             deb_lvl,
  output logic             irq
);
  localparam int PRE_W = 2 * ((1 << DIV_W) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic [1:0]       flt_cnt;
  logic             flt_q, prev_q, armed;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;

  wire       src     = loop_en ? pwm_loop : tach_in;
  wire       lvl     = sync_q[1];
  wire [1:0] flt_len = 2'd3 - deb_code;

  assign raw_lvl = lvl;
  assign deb_lvl = (flt_len == 2'd0) ? lvl : flt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], src};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q   <= 1'b0;
      flt_cnt <= '0;
    end else if (lvl == flt_q) begin
      flt_cnt <= '0;
    end else if (flt_len == 2'd0 || flt_cnt == flt_len - 2'd1) begin
      flt_q   <= lvl;
      flt_cnt <= '0;
    end else begin
      flt_cnt <= flt_cnt + 2'd1;
    end

  wire rise = deb_lvl & ~prev_q;
  wire fall = ~deb_lvl & prev_q;
  logic qual;
  always_comb
    case (edge_sel)
      2'b00:   qual = fall;
      2'b01:   qual = rise;
      default: qual = rise | fall;
    endcase

  wire             edge_hit = meas_en & qual;
  wire [PRE_W-1:0] pre_last = (PRE_W'(1) << (2 * div_code)) - PRE_W'(1);
  wire             tick     = meas_en & armed & ~edge_hit & (pre_cnt == pre_last);
  wire             sat_hit  = tick & (cnt == CNT_MAX - CNT_W'(1));
  wire             cap      = (edge_hit & armed) | sat_hit;
  wire [CNT_W-1:0] cap_val  = sat_hit ? CNT_MAX : cnt;
  wire             over     = thr_inv ? (cap_val < thr) : (cap_val > thr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= deb_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed     <= 1'b0;
      pre_cnt   <= '0;
      cnt       <= '0;
      meas_val  <= '0;
      meas_full <= 1'b0;
    end else if (!meas_en) begin
      armed     <= 1'b0;
      pre_cnt   <= '0;
      cnt       <= '0;
      meas_full <= 1'b0;
    end else begin
      if (edge_hit) begin
        armed   <= 1'b1;
        pre_cnt <= '0;
        cnt     <= '0;
      end else if (armed) begin
        pre_cnt <= (pre_cnt == pre_last) ? '0 : pre_cnt + PRE_W'(1);
        if (tick && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
      if (cap) begin
        meas_val  <= cap_val;
        meas_full <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       meas_new <= 1'b0;
    else if (cap)     meas_new <= 1'b1;
    else if (stat_rd) meas_new <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          irq <= 1'b0;
    else if (cap && thr_irq_en && over)  irq <= 1'b1;
    else if (irq_clr)                    irq <= 1'b0;
endmodule

module fan_tach_period_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_en,
  input logic             stat_rd,
  input logic             irq_clr,
  input logic             thr_irq_en,
  input logic             cap,
  input logic [CNT_W-1:0] meas_val,
  input logic             meas_full,
  input logic             meas_new,
  input logic             irq
);
  a_r1_off_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !meas_full);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cap) |=> !meas_new);
  a_r8_cap_sets_new: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> meas_new);
  a_r5_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(meas_val));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !thr_irq_en) |=> !irq);
endmodule

bind fan_tach_period fan_tach_period_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .stat_rd(stat_rd),
  .irq_clr(irq_clr), .thr_irq_en(thr_irq_en), .cap(cap),
  .meas_val(meas_val), .meas_full(meas_full), .meas_new(meas_new), .irq(irq)
);

// File: tb/fan_tach_period_bench.sv
module fan_tach_period_bench;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tach_in = 1'b0, pwm_loop = 1'b0, meas_en = 1'b0, loop_en = 1'b0;
  logic [1:0] edge_sel = 2'b01, deb_code = 2'b11;
  logic [3:0] div_code = '0;
  logic [CW-1:0] thr = '0;
  logic thr_irq_en = 1'b0, thr_inv = 1'b0, stat_rd = 1'b0, irq_clr = 1'b0;
  logic [CW-1:0] meas_val;
  logic meas_full, meas_new, raw_lvl, deb_lvl, irq;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  fan_tach_period #(.CNT_W(CW), .DIV_W(4)) u_fan_tach_period (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .pwm_loop(pwm_loop),
    .meas_en(meas_en), .loop_en(loop_en), .edge_sel(edge_sel),
    .deb_code(deb_code), .div_code(div_code), .thr(thr),
    .thr_irq_en(thr_irq_en), .thr_inv(thr_inv), .stat_rd(stat_rd),
    .irq_clr(irq_clr), .meas_val(meas_val), .meas_full(meas_full),
    .meas_new(meas_new), .raw_lvl(raw_lvl), .deb_lvl(deb_lvl), .irq(irq));

  typedef struct packed {
    logic [1:0] es;
    logic [3:0] dv;
    int         a;
    int         b;
    int         exp;
  } vec_t;

  // Expected count: interval / 4^dv - 1; any-edge mode measures the b phase.
  localparam vec_t VECS [7] = '{
    '{2'b01, 4'd0,  7,  5, 11},
    '{2'b00, 4'd0,  6,  9, 14},
    '{2'b10, 4'd0,  6,  9,  8},
    '{2'b01, 4'd1, 20, 20,  9},
    '{2'b10, 4'd1, 16,  8,  1},
    '{2'b01, 4'd2, 32, 32,  3},
    '{2'b00, 4'd0,  1,  1,  1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flip(input bit via_pwm);
    if (via_pwm) pwm_loop = ~pwm_loop;
    else         tach_in  = ~tach_in;
  endtask

  task automatic setup(input logic [1:0] es, input logic [3:0] dv, input bit via_pwm);
    meas_en = 1'b0;
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    if (via_pwm) pwm_loop = (es == 2'b00);
    else         tach_in  = (es == 2'b00);
    cyc(8);
    edge_sel = es;
    div_code = dv;
    meas_en  = 1'b1;
    cyc(4);
  endtask

  task automatic run_meas(input logic [1:0] es, input logic [3:0] dv,
                          input int a, input int b, input bit via_pwm);
    setup(es, dv, via_pwm);
    flip(via_pwm); cyc(a);
    flip(via_pwm); cyc(b);
    flip(via_pwm); cyc(12);
  endtask

  task automatic glitch_run(input logic [1:0] code);
    deb_code = code;
    setup(2'b01, 4'd0, 1'b0);
    tach_in = 1'b1; cyc(10);
    tach_in = 1'b0; cyc(10);
    tach_in = 1'b1; cyc(2);
    tach_in = 1'b0; cyc(18);
    tach_in = 1'b1; cyc(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R13 meas_val", int'(meas_val), 0);
    chk("R13 meas_full", int'(meas_full), 0);
    chk("R13 meas_new", int'(meas_new), 0);
    chk("R13 irq", int'(irq), 0);

    // R2 R4 R5 R7 R8: table of edge modes and prescaler codes
    for (int i = 0; i < 7; i++) begin
      run_meas(VECS[i].es, VECS[i].dv, VECS[i].a, VECS[i].b, 1'b0);
      chk($sformatf("R2/R5 vec%0d count", i), int'(meas_val), VECS[i].exp);
      chk($sformatf("R7 vec%0d full", i), int'(meas_full), 1);
      chk($sformatf("R8 vec%0d new", i), int'(meas_new), 1);
    end

    // R8: a status read clears the update flag
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0; cyc(1);
    chk("R8 read clears new", int'(meas_new), 0);

    // R1: disable clears full, and edges while disabled capture nothing
    meas_en = 1'b0; cyc(2);
    chk("R1 full cleared", int'(meas_full), 0);
    for (int k = 0; k < 6; k++) begin
      tach_in = ~tach_in; cyc(5);
    end
    chk("R1 no capture while off", int'(meas_new), 0);
    // R1: a lone arming edge captures nothing
    setup(2'b01, 4'd0, 1'b0);
    tach_in = 1'b1; cyc(12);
    chk("R1 arm only", int'(meas_new), 0);

    // R3: two-clock glitch filtered by a three-clock filter, passed by a two-clock one
    glitch_run(2'b00);
    chk("R3 three-clock filter", int'(meas_val), 39);
    glitch_run(2'b01);
    chk("R3 two-clock filter", int'(meas_val), 19);

    // R12 R3: latency of raw and filtered levels with the three-clock filter
    deb_code = 2'b00; meas_en = 1'b0; tach_in = 1'b0; cyc(10);
    tach_in = 1'b1; cyc(1);
    chk("R12 raw after 1", int'(raw_lvl), 0);
    cyc(1);
    chk("R12 raw after 2", int'(raw_lvl), 1);
    cyc(2);
    chk("R3 filtered after 4", int'(deb_lvl), 0);
    cyc(1);
    chk("R3 filtered after 5", int'(deb_lvl), 1);
    deb_code = 2'b11;

    // R6: a stalled input saturates and is captured without a second edge
    setup(2'b01, 4'd0, 1'b0);
    tach_in = 1'b1; cyc(1100);
    chk("R6 saturated value", int'(meas_val), (1 << CW) - 1);
    chk("R6 saturated new", int'(meas_new), 1);
    chk("R6 saturated full", int'(meas_full), 1);

    // R9: normal sense, sticky, write-one-to-clear
    thr = CW'(5); thr_irq_en = 1'b1; thr_inv = 1'b0;
    run_meas(2'b01, 4'd0, 5, 5, 1'b0);
    chk("R9 irq above threshold", int'(irq), 1);
    cyc(5);
    chk("R9 irq sticky", int'(irq), 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R9 irq cleared", int'(irq), 0);

    // R10: inverted sense
    thr_inv = 1'b1;
    run_meas(2'b01, 4'd0, 5, 5, 1'b0);
    chk("R10 no irq above threshold", int'(irq), 0);
    run_meas(2'b01, 4'd0, 2, 1, 1'b0);
    chk("R10 irq below threshold", int'(irq), 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;

    // R9: interrupt disabled
    thr_irq_en = 1'b0; thr_inv = 1'b0;
    run_meas(2'b01, 4'd0, 5, 5, 1'b0);
    chk("R9 irq disabled", int'(irq), 0);

    // R11: loopback measures the PWM line, the tach pin is held
    loop_en = 1'b1; tach_in = 1'b0;
    run_meas(2'b01, 4'd0, 10, 10, 1'b1);
    chk("R11 loopback count", int'(meas_val), 19);
    loop_en = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule